// File: doc/BRIEF.md
# Aperture Translation Lookaside Buffer

This block caches translations for a graphics aperture. A request carries an address. If the address falls inside the aperture, the block maps its page number to a physical page. Otherwise the address passes through untouched. Aperture membership is a base/mask compare. The cache has eight fully associative entries. When a lookup misses, the block reads one translation-table entry from main memory over a fetch port, and only one such read is outstanding at a time. Requests stall while that read is pending.

A 32-bit control register holds two bits. One is a runtime cache enable. The other forces the reported transfer-rate field to a fixed code. Disabling the cache flushes it. While disabled, every aperture request goes to memory. Fetched entries marked valid are dropped, but entries marked invalid are still cached, replacing the least recently used entry. Every control write is acknowledged only once an external posted-write buffer reports that it holds no dirty data. The register itself updates at once, even when a table fetch is in flight.

Top module: `aptlb_top`

## Requirements
- R1: After reset the control register reads zero, the cache is disabled and empty, `req_ready` is high, `rsp_valid`, `fetch_valid` and `cfg_wr_ack` are low, and `rate_view` equals `neg_rate`.
- R2: A control write keeps only bit 7 (cache enable) and bit 0 (rate override). All other bits of `cfg_rd_data` read zero.
- R3: When the override bit is 1, `rate_view` is 3'b001. When it is 0, `rate_view` equals `neg_rate`.
- R4: `cfg_wr_ack` is a pulse one cycle after the first clock edge following the write at which `wb_dirty` is low. It is never high right after an edge where `wb_dirty` was high. This holds for writes that set the enable and for writes that clear it.
- R5: `cfg_rd_data` shows the written value one cycle after the write, including while a table fetch is outstanding.
- R6: A request where `(req_addr & ap_mask) != ap_base` gets `rsp_valid` one cycle after acceptance, with `rsp_addr == req_addr`, `rsp_fault` low and no fetch.
- R7: With the cache enabled, a request whose page is cached gets its response one cycle after acceptance with no fetch. The response address is the cached page number concatenated with the request's low 12 offset bits.
- R8: On a miss, `fetch_valid` pulses for one cycle, one cycle after acceptance, with `fetch_vpn` equal to the request's page number. `req_ready` stays low until `fetch_rsp_valid`. The response follows one cycle later. The entry is then cached.
- R9: Table entries keep the valid flag in bit 0 and the physical page in bits 31:12. A response built from an entry whose flag is 0 has `rsp_fault` high, whether the entry came from a fetch or from a cache hit; `rsp_addr` is then unspecified.
- R10: With the cache disabled, every aperture request fetches from memory, and a fetched entry with flag 1 is not cached.
- R11: With the cache disabled, a fetched entry with flag 0 is cached. After the cache is re-enabled, that page hits, faulting, without a fetch.
- R12: A write that changes the enable from 1 to 0 invalidates every entry, so previously cached pages miss after re-enabling.
- R13: When all eight entries are in use, a fill replaces the entry touched least recently, where both hits and fills count as touches. Free entries are used before any replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_base | input | 32 | Aperture base for the masked compare |
| ap_mask | input | 32 | Aperture compare mask |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_addr | output | 32 | Translated or passed-through address |
| fetch_valid | output | 1 | Table-entry read pulse |
| fetch_vpn | output | 20 | Page number to read |
| fetch_rsp_valid | input | 1 | Table-entry read data valid |
| fetch_rsp_pte | input | 32 | Table entry read from memory |
| cfg_wr_valid | input | 1 | Control write strobe |
| cfg_wr_data | input | 32 | Control write data |
| cfg_wr_ack | output | 1 | Control write completion |
| cfg_rd_data | output | 32 | Current control register |
| wb_dirty | input | 1 | Posted-write buffer still holds dirty data |
| neg_rate | input | 3 | Negotiated rate code |
| rate_view | output | 3 | Rate code as reported |

## Verification
The embedded properties check several rules on every cycle. An acknowledge never follows a dirty sample. A disabled-mode aperture request always issues a fetch. An enabled hit never does. Requests stay stalled while a fetch pulse is out, and a flush empties every entry. The recency ages stay a permutation, and no two entries ever match the same page. Other behaviours need sequences of requests to become visible, so only the bench scenarios can show them. These are which entry an eviction picks, the rule that valid entries are dropped and invalid ones kept while disabled, and the faulting hit after re-enabling.

// File: rtl/aptlb_pkg.sv
package aptlb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tlb_state_e;

    localparam int CFG_W       = 32;
    localparam int CFG_EN_BIT  = 7;
    localparam int CFG_OVR_BIT = 0;
    localparam int RATE_W      = 3;
    localparam logic [RATE_W-1:0] RATE_FORCED = 3'b001;
endpackage

// File: rtl/aptlb_ctrl.sv
module aptlb_ctrl
    import aptlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              wb_dirty,
    input  logic [RATE_W-1:0] neg_rate,
    output logic [CFG_W-1:0]  rd_data,
    output logic              en,
    output logic              flush,
    output logic              ack,
    output logic [RATE_W-1:0] rate_view
);
    localparam logic [CFG_W-1:0] KEEP_MASK = (CFG_W'(1) << CFG_EN_BIT) | (CFG_W'(1) << CFG_OVR_BIT);

    typedef struct packed {
        logic en;
        logic ovr;
        logic pend;
        logic ack;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^(wr_data & ~KEEP_MASK);

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        if (s_q.pend && !wb_dirty) begin
            s_d.ack  = 1'b1;
            s_d.pend = 1'b0;
        end
        if (wr_valid) begin
            s_d.en   = wr_data[CFG_EN_BIT];
            s_d.ovr  = wr_data[CFG_OVR_BIT];
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data              = '0;
        rd_data[CFG_EN_BIT]  = s_q.en;
        rd_data[CFG_OVR_BIT] = s_q.ovr;
    end

    assign en        = s_q.en;
    assign ack       = s_q.ack;
    assign flush     = wr_valid && s_q.en && !wr_data[CFG_EN_BIT];
    assign rate_view = s_q.ovr ? RATE_FORCED : neg_rate;

    AST_ACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(wb_dirty)); // R4
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (rd_data[CFG_EN_BIT] == $past(wr_data[CFG_EN_BIT]))); // R5
endmodule

// File: rtl/aptlb_lru.sv
module aptlb_lru #(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       touch_valid,
    input  logic [$clog2(ENTRIES)-1:0] touch_idx,
    output logic [$clog2(ENTRIES)-1:0] victim_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_s;

    lru_s               s_d, s_q;
    logic [ENTRIES-1:0] zero_vec;
    logic [ENTRIES-1:0] old_vec;

    always_comb begin
        s_d = s_q;
        if (touch_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_q.age[i] < s_q.age[touch_idx]) s_d.age[i] = s_q.age[i] + IDX_W'(1);
            end
            s_d.age[touch_idx] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) s_q.age[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        victim_idx = '0;
        zero_vec   = '0;
        old_vec    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            zero_vec[i] = (s_q.age[i] == '0);
            old_vec[i]  = (s_q.age[i] == IDX_W'(ENTRIES-1));
            if (old_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    AST_AGE_NEWEST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(zero_vec)); // R13
    AST_AGE_OLDEST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(old_vec)); // R13
endmodule

// File: rtl/aptlb_cam.sv
module aptlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VPN_W-1:0]           lk_vpn,
    output logic                       lk_hit,
    output logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic                       lk_tv,
    output logic [PPN_W-1:0]           lk_ppn,
    input  logic                       wr_en,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic                       wr_tv,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  logic [$clog2(ENTRIES)-1:0] victim_idx,
    output logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic                       flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]            ev;
        logic [ENTRIES-1:0]            tv;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
    } cam_s;

    cam_s               s_d, s_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [IDX_W-1:0]   same_idx;
    logic [IDX_W-1:0]   free_idx;

    always_comb begin
        lk_match = '0;
        wr_match = '0;
        lk_idx   = '0;
        same_idx = '0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_match[i] = s_q.ev[i] && (s_q.tag[i] == lk_vpn);
            wr_match[i] = s_q.ev[i] && (s_q.tag[i] == wr_vpn);
            if (lk_match[i]) lk_idx = IDX_W'(i);
            if (wr_match[i]) same_idx = IDX_W'(i);
        end
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (!s_q.ev[i]) free_idx = IDX_W'(i);
        end
        lk_hit = |lk_match;
        lk_tv  = s_q.tv[lk_idx];
        lk_ppn = s_q.ppn[lk_idx];
        if (|wr_match)     wr_idx = same_idx;
        else if (~&s_q.ev) wr_idx = free_idx;
        else               wr_idx = victim_idx;
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ev[wr_idx]  = 1'b1;
            s_d.tv[wr_idx]  = wr_tv;
            s_d.tag[wr_idx] = wr_vpn;
            s_d.ppn[wr_idx] = wr_ppn;
        end
        if (flush) s_d.ev = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.ev == '0)); // R12
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_match) <= 1); // R8
endmodule

// File: rtl/aptlb_top.sv
module aptlb_top
    import aptlb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRIES    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      ap_base,
    input  logic [ADDR_W-1:0]      ap_mask,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [ADDR_W-1:0]      rsp_addr,
    output logic                   fetch_valid,
    output logic [ADDR_W-PAGE_SHIFT-1:0] fetch_vpn,
    input  logic                   fetch_rsp_valid,
    input  logic [ADDR_W-1:0]      fetch_rsp_pte,
    input  logic                   cfg_wr_valid,
    input  logic [CFG_W-1:0]       cfg_wr_data,
    output logic                   cfg_wr_ack,
    output logic [CFG_W-1:0]       cfg_rd_data,
    input  logic                   wb_dirty,
    input  logic [RATE_W-1:0]      neg_rate,
    output logic [RATE_W-1:0]      rate_view
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;
    localparam int PPN_W = VPN_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tlb_state_e            st;
        logic [VPN_W-1:0]      vpn;
        logic [PAGE_SHIFT-1:0] off;
        logic                  rsp_v;
        logic                  rsp_f;
        logic [ADDR_W-1:0]     rsp_a;
        logic                  fet_v;
    } top_s;

    top_s             s_d, s_q;
    logic             en;
    logic             flush;
    logic             in_ap;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             lk_tv;
    logic [PPN_W-1:0] lk_ppn;
    logic             cam_wr;
    logic [IDX_W-1:0] cam_wr_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             touch_valid;
    logic [IDX_W-1:0] touch_idx;
    logic             unused_pte_bits;

    assign unused_pte_bits = ^fetch_rsp_pte[PAGE_SHIFT-1:1];
    assign in_ap           = ((req_addr & ap_mask) == ap_base);

    aptlb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (cfg_wr_valid),
        .wr_data   (cfg_wr_data),
        .wb_dirty  (wb_dirty),
        .neg_rate  (neg_rate),
        .rd_data   (cfg_rd_data),
        .en        (en),
        .flush     (flush),
        .ack       (cfg_wr_ack),
        .rate_view (rate_view)
    );

    aptlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (req_addr[ADDR_W-1:PAGE_SHIFT]),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_tv      (lk_tv),
        .lk_ppn     (lk_ppn),
        .wr_en      (cam_wr),
        .wr_vpn     (s_q.vpn),
        .wr_tv      (fetch_rsp_pte[0]),
        .wr_ppn     (fetch_rsp_pte[ADDR_W-1:PAGE_SHIFT]),
        .victim_idx (victim_idx),
        .wr_idx     (cam_wr_idx),
        .flush      (flush)
    );

    aptlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .victim_idx  (victim_idx)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rsp_v   = 1'b0;
        s_d.fet_v   = 1'b0;
        cam_wr      = 1'b0;
        touch_valid = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!in_ap) begin
                        s_d.rsp_v = 1'b1;
                        s_d.rsp_f = 1'b0;
                        s_d.rsp_a = req_addr;
                    end else if (en && lk_hit) begin
                        s_d.rsp_v   = 1'b1;
                        s_d.rsp_f   = !lk_tv;
                        s_d.rsp_a   = {lk_ppn, req_addr[PAGE_SHIFT-1:0]};
                        touch_valid = 1'b1;
                    end else begin
                        s_d.fet_v = 1'b1;
                        s_d.vpn   = req_addr[ADDR_W-1:PAGE_SHIFT];
                        s_d.off   = req_addr[PAGE_SHIFT-1:0];
                        s_d.st    = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (fetch_rsp_valid) begin
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_f = !fetch_rsp_pte[0];
                    s_d.rsp_a = {fetch_rsp_pte[ADDR_W-1:PAGE_SHIFT], s_q.off};
                    if (en || !fetch_rsp_pte[0]) begin
                        cam_wr      = 1'b1;
                        touch_valid = 1'b1;
                    end
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    assign touch_idx = cam_wr ? cam_wr_idx : lk_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign rsp_valid   = s_q.rsp_v;
    assign rsp_fault   = s_q.rsp_f;
    assign rsp_addr    = s_q.rsp_a;
    assign fetch_valid = s_q.fet_v;
    assign fetch_vpn   = s_q.vpn;

    AST_BYPASS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_ap && !en) |=> fetch_valid); // R10
    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_ap && en && lk_hit) |=> (rsp_valid && !fetch_valid)); // R7
    AST_STALL_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !req_ready); // R8
    AST_RATE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[CFG_OVR_BIT] |-> (rate_view == RATE_FORCED)); // R3
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !in_ap) |=> (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr))); // R6
endmodule

// File: tb/aptlb_top_bench.sv
module aptlb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ap_base = 32'hE000_0000;
    logic [31:0] ap_mask = 32'hF000_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault;
    logic [31:0] rsp_addr;
    logic        fetch_valid;
    logic [19:0] fetch_vpn;
    logic        fetch_rsp_valid = 1'b0;
    logic [31:0] fetch_rsp_pte = '0;
    logic        cfg_wr_valid = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_wr_ack;
    logic [31:0] cfg_rd_data;
    logic        wb_dirty = 1'b0;
    logic [2:0]  neg_rate = 3'b100;
    logic [2:0]  rate_view;

    int n_tests = 0;
    int n_fail  = 0;

    logic [19:0] m_vpn[$];
    logic [31:0] m_pte[$];
    bit          en_m  = 1'b0;
    bit          ovr_m = 1'b0;
    bit          mid_cfg = 1'b0;
    logic [31:0] mid_data = '0;

    always #10 clk = ~clk;

    aptlb_top u_aptlb_top (
        .clk(clk), .rst_n(rst_n), .ap_base(ap_base), .ap_mask(ap_mask),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
        .fetch_valid(fetch_valid), .fetch_vpn(fetch_vpn),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_pte(fetch_rsp_pte),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data), .cfg_wr_ack(cfg_wr_ack),
        .cfg_rd_data(cfg_rd_data), .wb_dirty(wb_dirty), .neg_rate(neg_rate), .rate_view(rate_view)
    );

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(logic [19:0] v);
        logic [19:0] p;
        p = v * 20'd7 + 20'h123;
        return {p, 11'b0, ((32'(v) % 5) != 3)};
    endfunction

    function automatic int m_find(logic [19:0] v);
        for (int i = 0; i < m_vpn.size(); i++) if (m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic m_install(logic [19:0] v, logic [31:0] p);
        int i;
        i = m_find(v);
        if (i >= 0) begin
            m_vpn.delete(i);
            m_pte.delete(i);
        end else if (m_vpn.size() == 8) begin
            void'(m_vpn.pop_back());
            void'(m_pte.pop_back());
        end
        m_vpn.push_front(v);
        m_pte.push_front(p);
    endtask

    task automatic chk_rate();
        logic [2:0] e;
        e = ovr_m ? 3'b001 : neg_rate;
        chk(rate_view == e, "R3 rate view", 32'(rate_view), 32'(e));
    endtask

    task automatic cfg_write(logic [31:0] data, int dirty);
        @(negedge clk);
        cfg_wr_valid = 1'b1;
        cfg_wr_data  = data;
        wb_dirty     = (dirty > 0);
        if (en_m && !data[7]) begin
            m_vpn.delete();
            m_pte.delete();
        end
        en_m  = data[7];
        ovr_m = data[0];
        @(negedge clk);
        cfg_wr_valid = 1'b0;
        chk(cfg_rd_data == (data & 32'h81), "R2 R5 register readback", cfg_rd_data, data & 32'h81);
        chk(cfg_wr_ack == 1'b0, "R4 ack too early", 32'(cfg_wr_ack), 0);
        chk_rate();
        repeat (dirty) begin
            @(negedge clk);
            chk(cfg_wr_ack == 1'b0, "R4 ack while dirty", 32'(cfg_wr_ack), 0);
        end
        wb_dirty = 1'b0;
        @(negedge clk);
        chk(cfg_wr_ack == 1'b1, "R4 ack after drain", 32'(cfg_wr_ack), 1);
        @(negedge clk);
        chk(cfg_wr_ack == 1'b0, "R4 ack is a pulse", 32'(cfg_wr_ack), 0);
    endtask

    task automatic do_req(logic [31:0] addr, output bit fetched);
        logic [19:0] vpn;
        logic [31:0] pte;
        bit          in_ap;
        int          idx;
        int          lat;
        vpn     = addr[31:12];
        in_ap   = ((addr & ap_mask) == ap_base);
        fetched = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        idx       = m_find(vpn);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (!in_ap) begin
            chk(rsp_valid && !fetch_valid && !rsp_fault, "R6 outside aperture response", {rsp_valid, fetch_valid, rsp_fault}, 3'b100);
            chk(rsp_addr == addr, "R6 passthrough address", rsp_addr, addr);
        end else if (en_m && idx >= 0) begin
            pte = m_pte[idx];
            chk(rsp_valid && !fetch_valid, "R7 hit without fetch", {rsp_valid, fetch_valid}, 2'b10);
            chk(rsp_fault == !pte[0], "R9 hit fault flag", 32'(rsp_fault), 32'(!pte[0]));
            if (pte[0]) chk(rsp_addr == {pte[31:12], addr[11:0]}, "R7 hit address", rsp_addr, {pte[31:12], addr[11:0]});
            m_install(vpn, pte);
        end else begin
            fetched = 1'b1;
            chk(fetch_valid && !rsp_valid && fetch_vpn == vpn, en_m ? "R8 fetch on miss" : "R10 fetch while disabled",
                32'(fetch_vpn), 32'(vpn));
            lat = $urandom_range(0, 3);
            repeat (lat) begin
                @(negedge clk);
                chk(!req_ready && !fetch_valid, "R8 stall during fetch", {req_ready, fetch_valid}, 0);
            end
            if (mid_cfg) begin
                mid_cfg = 1'b0;
                cfg_write(mid_data, 0);
                chk(!req_ready, "R5 fetch still outstanding", 32'(req_ready), 0);
            end
            pte             = pte_of(vpn);
            fetch_rsp_valid = 1'b1;
            fetch_rsp_pte   = pte;
            @(negedge clk);
            fetch_rsp_valid = 1'b0;
            chk(rsp_valid && req_ready, "R8 response after fetch", {rsp_valid, req_ready}, 2'b11);
            chk(rsp_fault == !pte[0], "R9 fetched fault flag", 32'(rsp_fault), 32'(!pte[0]));
            if (pte[0]) chk(rsp_addr == {pte[31:12], addr[11:0]}, "R8 fetched address", rsp_addr, {pte[31:12], addr[11:0]});
            if (en_m || !pte[0]) m_install(vpn, pte);
        end
    endtask

    function automatic logic [31:0] pg(int n);
        return 32'hE000_0000 | (32'(n) << 12) | 32'h0000_0ABC;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit f;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd_data == 0, "R1 register reset", cfg_rd_data, 0);
        chk(req_ready && !rsp_valid && !fetch_valid && !cfg_wr_ack, "R1 idle outputs",
            {req_ready, rsp_valid, fetch_valid, cfg_wr_ack}, 4'b1000);
        chk(rate_view == neg_rate, "R1 rate passthrough", 32'(rate_view), 32'(neg_rate));

        cfg_write(32'hFFFF_FFFF, 3);
        chk(rate_view == 3'b001, "R3 forced code", 32'(rate_view), 1);
        neg_rate = 3'b010;
        cfg_write(32'h0000_0080, 2);
        chk(rate_view == 3'b010, "R3 passthrough when clear", 32'(rate_view), 2);

        do_req(pg(1), f);
        chk(f == 1'b1, "R8 first access misses", 32'(f), 1);
        do_req(pg(1) ^ 32'h123, f);
        chk(f == 1'b0, "R8 refill is cached", 32'(f), 0);
        do_req(pg(4), f);
        chk(f == 1'b1 && rsp_fault, "R9 invalid entry faults", {f, rsp_fault}, 2'b11);
        do_req(pg(4), f);
        chk(f == 1'b0 && rsp_fault, "R9 cached invalid entry faults", {f, rsp_fault}, 2'b01);
        do_req(32'h3456_7890, f);
        chk(f == 1'b0, "R6 no fetch outside", 32'(f), 0);

        cfg_write(32'h0, 0);
        cfg_write(32'h80, 1);
        for (int i = 20; i < 28; i++) do_req(pg(i), f);
        do_req(pg(20), f);
        chk(f == 1'b0, "R13 touch oldest", 32'(f), 0);
        do_req(pg(28), f);
        chk(f == 1'b1, "R13 ninth page fills", 32'(f), 1);
        do_req(pg(20), f);
        chk(f == 1'b0, "R13 recently hit entry kept", 32'(f), 0);
        do_req(pg(21), f);
        chk(f == 1'b1, "R13 least recent entry evicted", 32'(f), 1);

        cfg_write(32'h0, 2);
        do_req(pg(1), f);
        chk(f == 1'b1, "R10 disabled fetch one", 32'(f), 1);
        do_req(pg(1), f);
        chk(f == 1'b1, "R10 disabled fetch two", 32'(f), 1);
        do_req(pg(9), f);
        chk(f == 1'b1, "R11 invalid fetched while disabled", 32'(f), 1);
        cfg_write(32'h80, 0);
        do_req(pg(9), f);
        chk(f == 1'b0 && rsp_fault, "R11 invalid entry kept", {f, rsp_fault}, 2'b01);
        do_req(pg(1), f);
        chk(f == 1'b1, "R10 valid entry not kept", 32'(f), 1);
        do_req(pg(20), f);
        chk(f == 1'b1, "R12 flush dropped old page", 32'(f), 1);

        mid_cfg  = 1'b1;
        mid_data = 32'h0000_0081;
        do_req(pg(30), f);
        chk(cfg_rd_data == 32'h81, "R5 value during fetch", cfg_rd_data, 32'h81);

        for (int it = 0; it < 400; it++) begin
            logic [31:0] a;
            logic [31:0] d;
            if ($urandom_range(0, 19) == 0) begin
                neg_rate = 3'($urandom);
                d = $urandom;
                d[7] = ($urandom_range(0, 3) != 0);
                cfg_write(d, $urandom_range(0, 3));
            end
            if ($urandom_range(0, 29) == 0) begin
                mid_cfg  = 1'b1;
                mid_data = $urandom;
                mid_data[7] = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 9) == 0) a = 32'h3000_0000 | ($urandom & 32'h0FFF_FFFF);
            else a = 32'hE000_0000 | (32'($urandom_range(0, 11)) << 12) | ($urandom & 32'hFFF);
            do_req(a, f);
            chk_rate();
        end
        mid_cfg = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule